// File: doc/BRIEF.md
# Radio Command Strobe Sequencer

This block sits behind an SPI slave front end that has already split each header byte into a strobe pulse and a six-bit strobe address. It turns those single-byte commands into moves of a small radio control state machine. It owns the 3-bit chip-state code that goes into the status byte. It drives the SO ready level that is high while a soft reset is in progress. It issues one-cycle flush pulses to the transmit and receive FIFOs. Events whose timing is set elsewhere are one-cycle inputs: reset completion, transmit underflow and receive overflow.

Most commands act on the clock edge that samples them. The power-down and oscillator-off commands are different: they are held as a pending request and carried out only when chip select is released. A reset command cancels such a request. Flush commands take effect only in the idle, receive-overflow and transmit-underflow states. Several commands may follow one another inside one chip-select frame.

Top module: `strobe_seq`

## Requirements
- R1: After rst_ni is released, state_o is 0 (IDLE), so_o is 0 and both flush outputs are 0.
- R2: State codes are IDLE=0, RX=1, TX=2, SLEEP=3, XOFF=4, RESET=5, RX_OVF=6, TX_UNF=7. A command is valid only when strobe_i=1 and cs_n_i=0, and it is visible on the outputs after the next clock edge. Command addresses are 0x30 reset, 0x32 oscillator off, 0x34 receive, 0x35 transmit, 0x36 idle, 0x39 power down, 0x3A flush RX and 0x3B flush TX.
- R3: A reset command in any active state (IDLE, RX, TX, RX_OVF, TX_UNF) moves the block to RESET. so_o is 1 exactly while the state is RESET. The state stays RESET, ignoring all commands, until reset_done_i, which moves it to IDLE.
- R4: The receive and transmit commands move the block to RX or TX from IDLE, RX or TX, and are ignored in RX_OVF and TX_UNF. The idle command moves the block to IDLE from any active state.
- R5: A power-down command in an active state leaves the state unchanged until the cycle in which cs_n_i rises. In that cycle the state becomes SLEEP and flush_tx_o and flush_rx_o each pulse for one cycle.
- R6: An oscillator-off command in an active state is likewise held until cs_n_i rises, and then moves the block to XOFF with no flush pulse. When both deferred commands arrive in one frame, the latest one wins.
- R7: A reset command that arrives while a deferred command is pending cancels it, so the next rise of cs_n_i changes nothing.
- R8: The flush-RX and flush-TX commands pulse their flush output for one cycle only in IDLE, RX_OVF or TX_UNF, and are ignored in every other state. Flush-RX in RX_OVF and flush-TX in TX_UNF also move the block to IDLE.
- R9: The unassigned addresses 0x31, 0x33, 0x37, 0x38, 0x3C and 0x3D, addresses outside 0x30 to 0x3D, and any strobe given while cs_n_i is high change neither the state nor the flush outputs.
- R10: In SLEEP and XOFF, commands are ignored. A fall of cs_n_i returns the block to IDLE.
- R11: tx_underflow_i in TX moves the block to TX_UNF, and rx_overflow_i in RX moves it to RX_OVF. A valid command in the same cycle takes precedence over the event. Each event is ignored in every other state.
- R12: Consecutive commands inside one chip-select frame each take effect without cs_n_i going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | SPI chip select, active low, synchronous to clk_i |
| strobe_i | input | 1 | One-cycle command pulse from the SPI front end |
| strobe_addr_i | input | 6 | Command address that goes with strobe_i |
| reset_done_i | input | 1 | Soft reset sequence complete |
| tx_underflow_i | input | 1 | Transmit FIFO underflow event |
| rx_overflow_i | input | 1 | Receive FIFO overflow event |
| state_o | output | 3 | Chip-state code for the status byte |
| flush_tx_o | output | 1 | One-cycle transmit FIFO flush |
| flush_rx_o | output | 1 | One-cycle receive FIFO flush |
| so_o | output | 1 | SO ready level, high while reset is in progress |

## Verification
The hardest thing to reach from the ports is a command arriving while the block is in SLEEP or XOFF. A command needs chip select low, and chip select going low is itself the wake-up. The only such case is a strobe in the same cycle as the falling edge of chip select. The bench builds exactly that cycle for every address, starting from both low-power states. It reaches each of the eight start states through a fixed preamble. Each command in the range is then tried from each state, and a deferred command is followed by a release of chip select. Expected states and flush pulses come from a small table model of the requirements.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int ADDR_W  = 6;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_RX     = 3'd1,
    ST_TX     = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_XOFF   = 3'd4,
    ST_RESET  = 3'd5,
    ST_RX_OVF = 3'd6,
    ST_TX_UNF = 3'd7
  } radio_state_e;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_RESET, CMD_XOFF, CMD_RX, CMD_TX,
    CMD_IDLE, CMD_PWD, CMD_FRX, CMD_FTX
  } cmd_e;

  typedef enum logic [1:0] {
    DEF_NONE = 2'd0,
    DEF_PWD  = 2'd1,
    DEF_XOFF = 2'd2
  } defer_e;

  localparam logic [ADDR_W-1:0] A_RESET = 6'h30;
  localparam logic [ADDR_W-1:0] A_XOFF  = 6'h32;
  localparam logic [ADDR_W-1:0] A_RX    = 6'h34;
  localparam logic [ADDR_W-1:0] A_TX    = 6'h35;
  localparam logic [ADDR_W-1:0] A_IDLE  = 6'h36;
  localparam logic [ADDR_W-1:0] A_PWD   = 6'h39;
  localparam logic [ADDR_W-1:0] A_FRX   = 6'h3A;
  localparam logic [ADDR_W-1:0] A_FTX   = 6'h3B;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import strobe_pkg::*;
(
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (valid_i) begin
      unique case (addr_i)
        A_RESET: cmd_o = CMD_RESET;
        A_XOFF:  cmd_o = CMD_XOFF;
        A_RX:    cmd_o = CMD_RX;
        A_TX:    cmd_o = CMD_TX;
        A_IDLE:  cmd_o = CMD_IDLE;
        A_PWD:   cmd_o = CMD_PWD;
        A_FRX:   cmd_o = CMD_FRX;
        A_FTX:   cmd_o = CMD_FTX;
        default: cmd_o = CMD_NONE; // reserved or out of range
      endcase
    end
  end
endmodule

// File: rtl/cs_edge_det.sv
module cs_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic rise_o,
  output logic fall_o
);
  logic cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_q <= 1'b1;
    else         cs_n_q <= cs_n_i;
  end

  assign rise_o = !cs_n_q && cs_n_i;
  assign fall_o = cs_n_q && !cs_n_i;
endmodule

// File: rtl/defer_latch.sv
module defer_latch
  import strobe_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_pwd_i,
  input  logic   set_xoff_i,
  input  logic   clear_i,
  output defer_e pend_o
);
  defer_e pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= DEF_NONE;
    else if (clear_i)    pend_q <= DEF_NONE;
    else if (set_pwd_i)  pend_q <= DEF_PWD;
    else if (set_xoff_i) pend_q <= DEF_XOFF;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/radio_fsm.sv
module radio_fsm
  import strobe_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_e         cmd_i,
  input  logic         cs_rise_i,
  input  logic         cs_fall_i,
  input  defer_e       pend_i,
  input  logic         reset_done_i,
  input  logic         tx_underflow_i,
  input  logic         rx_overflow_i,
  output radio_state_e state_o,
  output logic         flush_tx_o,
  output logic         flush_rx_o,
  output logic         set_pwd_o,
  output logic         set_xoff_o,
  output logic         clear_o
);
  radio_state_e state_q, state_d;
  logic ftx_q, frx_q, ftx_d, frx_d;
  logic active, flush_ok, run_ok;

  assign active   = state_q inside {ST_IDLE, ST_RX, ST_TX, ST_RX_OVF, ST_TX_UNF};
  assign flush_ok = state_q inside {ST_IDLE, ST_RX_OVF, ST_TX_UNF};
  assign run_ok   = state_q inside {ST_IDLE, ST_RX, ST_TX};

  assign set_pwd_o  = active && !cs_rise_i && (cmd_i == CMD_PWD);
  assign set_xoff_o = active && !cs_rise_i && (cmd_i == CMD_XOFF);
  assign clear_o    = cs_rise_i || (active && cmd_i == CMD_RESET);

  always_comb begin
    state_d = state_q;
    ftx_d   = 1'b0;
    frx_d   = 1'b0;
    unique case (state_q)
      ST_RESET: if (reset_done_i) state_d = ST_IDLE;
      ST_SLEEP,
      ST_XOFF:  if (cs_fall_i) state_d = ST_IDLE;
      default: begin
        if (cs_rise_i && pend_i == DEF_PWD) begin
          state_d = ST_SLEEP;
          ftx_d   = 1'b1;
          frx_d   = 1'b1;
        end else if (cs_rise_i && pend_i == DEF_XOFF) begin
          state_d = ST_XOFF;
        end else begin
          unique case (cmd_i)
            CMD_RESET: state_d = ST_RESET;
            CMD_RX:    if (run_ok) state_d = ST_RX;
            CMD_TX:    if (run_ok) state_d = ST_TX;
            CMD_IDLE:  state_d = ST_IDLE;
            CMD_FRX: if (flush_ok) begin
              frx_d = 1'b1;
              if (state_q == ST_RX_OVF) state_d = ST_IDLE;
            end
            CMD_FTX: if (flush_ok) begin
              ftx_d = 1'b1;
              if (state_q == ST_TX_UNF) state_d = ST_IDLE;
            end
            default: begin
              if (state_q == ST_TX && tx_underflow_i) state_d = ST_TX_UNF;
              if (state_q == ST_RX && rx_overflow_i)  state_d = ST_RX_OVF;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ftx_q   <= 1'b0;
      frx_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ftx_q   <= ftx_d;
      frx_q   <= frx_d;
    end
  end

  assign state_o    = state_q;
  assign flush_tx_o = ftx_q;
  assign flush_rx_o = frx_q;
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               strobe_i,
  input  logic [ADDR_W-1:0]  strobe_addr_i,
  input  logic               reset_done_i,
  input  logic               tx_underflow_i,
  input  logic               rx_overflow_i,
  output logic [STATE_W-1:0] state_o,
  output logic               flush_tx_o,
  output logic               flush_rx_o,
  output logic               so_o
);
  cmd_e         cmd;
  defer_e       pend;
  radio_state_e state;
  logic cs_rise, cs_fall, set_pwd, set_xoff, clr;

  strobe_decode u_dec (
    .valid_i (strobe_i && !cs_n_i),
    .addr_i  (strobe_addr_i),
    .cmd_o   (cmd)
  );

  cs_edge_det u_cs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_n_i),
    .rise_o (cs_rise),
    .fall_o (cs_fall)
  );

  defer_latch u_def (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_pwd_i  (set_pwd),
    .set_xoff_i (set_xoff),
    .clear_i    (clr),
    .pend_o     (pend)
  );

  radio_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_i          (cmd),
    .cs_rise_i      (cs_rise),
    .cs_fall_i      (cs_fall),
    .pend_i         (pend),
    .reset_done_i   (reset_done_i),
    .tx_underflow_i (tx_underflow_i),
    .rx_overflow_i  (rx_overflow_i),
    .state_o        (state),
    .flush_tx_o     (flush_tx_o),
    .flush_rx_o     (flush_rx_o),
    .set_pwd_o      (set_pwd),
    .set_xoff_o     (set_xoff),
    .clear_o        (clr)
  );

  assign state_o = state;
  assign so_o    = (state == ST_RESET);
endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk
  import strobe_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_n_i,
  input logic               strobe_i,
  input logic [ADDR_W-1:0]  strobe_addr_i,
  input logic               reset_done_i,
  input logic               tx_underflow_i,
  input logic [STATE_W-1:0] state_o,
  input logic               flush_tx_o,
  input logic               flush_rx_o,
  input logic               so_o
);
  logic act;
  assign act = state_o inside {ST_IDLE, ST_RX, ST_TX, ST_RX_OVF, ST_TX_UNF};

  // R3
  p_rst_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !cs_n_i && strobe_addr_i == A_RESET && act)
      |=> (state_o == ST_RESET && so_o));

  // R3
  p_reset_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RESET && !reset_done_i) |=> (state_o == ST_RESET));

  // R5
  p_sleep_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP && $past(state_o) != ST_SLEEP)
      |-> (flush_tx_o && flush_rx_o));

  // R6
  p_defer_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == ST_SLEEP || state_o == ST_XOFF) && $past(state_o) != state_o)
      |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

  // R8
  p_flush_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flush_tx_o || flush_rx_o) && state_o != ST_SLEEP)
      |-> ($past(state_o) inside {ST_IDLE, ST_RX_OVF, ST_TX_UNF}));

  // R11
  p_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TX && tx_underflow_i && !strobe_i && !cs_n_i)
      |=> (state_o == ST_TX_UNF));

  // R10
  p_sleep_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP && cs_n_i) |=> (state_o == ST_SLEEP));
endmodule

bind strobe_seq strobe_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_n_i         (cs_n_i),
  .strobe_i       (strobe_i),
  .strobe_addr_i  (strobe_addr_i),
  .reset_done_i   (reset_done_i),
  .tx_underflow_i (tx_underflow_i),
  .state_o        (state_o),
  .flush_tx_o     (flush_tx_o),
  .flush_rx_o     (flush_rx_o),
  .so_o           (so_o)
);

// File: tb/tb_strobe_seq.sv
module tb_strobe_seq;
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_TX = 3'd2, S_SLEEP = 3'd3,
                         S_XOFF = 3'd4, S_RESET = 3'd5, S_ROVF = 3'd6, S_TUNF = 3'd7;
  localparam logic [5:0] C_RST = 6'h30, C_XOFF = 6'h32, C_RX = 6'h34, C_TX = 6'h35,
                         C_IDLE = 6'h36, C_PWD = 6'h39, C_FRX = 6'h3A, C_FTX = 6'h3B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, stb = 1'b0, rdone = 1'b0, tunf = 1'b0, rovf = 1'b0;
  logic [5:0] addr = '0;
  logic [2:0] state;
  logic ftx, frx, so;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  strobe_seq dut (
    .clk_i (clk), .rst_ni (rst_n), .cs_n_i (cs_n), .strobe_i (stb),
    .strobe_addr_i (addr), .reset_done_i (rdone), .tx_underflow_i (tunf),
    .rx_overflow_i (rovf), .state_o (state), .flush_tx_o (ftx),
    .flush_rx_o (frx), .so_o (so)
  );

  function automatic logic is_act(input logic [2:0] s);
    return s inside {S_IDLE, S_RX, S_TX, S_ROVF, S_TUNF};
  endfunction

  function automatic logic [2:0] m_next(input logic [2:0] s, input logic [5:0] a);
    if (!is_act(s)) return s;
    case (a)
      C_RST:  return S_RESET;
      C_RX:   return (s inside {S_IDLE, S_RX, S_TX}) ? S_RX : s;
      C_TX:   return (s inside {S_IDLE, S_RX, S_TX}) ? S_TX : s;
      C_IDLE: return S_IDLE;
      C_FRX:  return (s == S_ROVF) ? S_IDLE : s;
      C_FTX:  return (s == S_TUNF) ? S_IDLE : s;
      default: return s;
    endcase
  endfunction

  function automatic logic flush_ok(input logic [2:0] s);
    return s inside {S_IDLE, S_ROVF, S_TUNF};
  endfunction

  task automatic check(input string req, input logic [2:0] es, input logic eftx, input logic efrx);
    logic [5:0] act, exp;
    act = {so, ftx, frx, state};
    exp = {es == S_RESET, eftx, efrx, es};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {so,ftx,frx,state} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [5:0] a);
    @(negedge clk); stb = 1'b1; addr = a;
    @(negedge clk); stb = 1'b0;
  endtask
  task automatic cs_up();   @(negedge clk); cs_n = 1'b1; @(negedge clk); endtask
  task automatic cs_down(); @(negedge clk); cs_n = 1'b0; @(negedge clk); endtask
  task automatic p_done();  @(negedge clk); rdone = 1'b1; @(negedge clk); rdone = 1'b0; endtask
  task automatic p_unf();   @(negedge clk); tunf = 1'b1;  @(negedge clk); tunf = 1'b0; endtask
  task automatic p_ovf();   @(negedge clk); rovf = 1'b1;  @(negedge clk); rovf = 1'b0; endtask

  task automatic goto(input logic [2:0] s);
    cs_down();
    strobe(C_RST);
    if (s == S_RESET) return;
    p_done();
    case (s)
      S_RX:    strobe(C_RX);
      S_TX:    strobe(C_TX);
      S_ROVF:  begin strobe(C_RX); p_ovf(); end
      S_TUNF:  begin strobe(C_TX); p_unf(); end
      S_SLEEP: begin strobe(C_PWD);  cs_up(); end
      S_XOFF:  begin strobe(C_XOFF); cs_up(); end
      default: ;
    endcase
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", S_IDLE, 1'b0, 1'b0);

    // R9: strobe while chip select high is ignored
    @(negedge clk); stb = 1'b1; addr = C_TX; @(negedge clk); stb = 1'b0;
    check("R9 strobe with cs high", S_IDLE, 1'b0, 1'b0);

    // sweep: every start state x every address in 0x30..0x3F
    for (int s = 0; s < 8; s++) begin
      for (int a = 6'h30; a <= 6'h3F; a++) begin
        logic [2:0] st, en;
        logic [5:0] aa;
        logic pend_pwd, pend_xoff, eft, efr;
        st = 3'(s); aa = 6'(a);
        goto(st);
        if (st == S_SLEEP || st == S_XOFF) begin
          // R10: strobe in the cycle chip select falls is ignored; wake to IDLE
          @(negedge clk); cs_n = 1'b0; stb = 1'b1; addr = aa;
          @(negedge clk); stb = 1'b0;
          check("R10 wake with strobe", S_IDLE, 1'b0, 1'b0);
        end else begin
          strobe(aa);
          en  = m_next(st, aa);
          eft = (aa == C_FTX) && flush_ok(st) && is_act(st);
          efr = (aa == C_FRX) && flush_ok(st) && is_act(st);
          pend_pwd  = is_act(st) && aa == C_PWD;
          pend_xoff = is_act(st) && aa == C_XOFF;
          check((aa inside {C_FRX, C_FTX}) ? "R8 flush gate" :
                (aa inside {C_RX, C_TX, C_IDLE}) ? "R4 run command" :
                (aa == C_RST) ? "R3 reset command" :
                (aa inside {C_PWD, C_XOFF}) ? "R5 deferred held" : "R9 reserved address",
                en, eft, efr);
          cs_up();
          if (pend_pwd)       check("R5 power down at cs rise", S_SLEEP, 1'b1, 1'b1);
          else if (pend_xoff) check("R6 osc off at cs rise", S_XOFF, 1'b0, 1'b0);
          else                check("R2 cs rise no change", en, 1'b0, 1'b0);
        end
      end
    end

    // R9: out-of-range addresses
    goto(S_RX);
    strobe(6'h00); check("R9 addr 0x00", S_RX, 1'b0, 1'b0);
    strobe(6'h2F); check("R9 addr 0x2F", S_RX, 1'b0, 1'b0);

    // R3: reset holds, commands ignored, so_o high, then done
    goto(S_RESET);
    strobe(C_IDLE); check("R3 command ignored in reset", S_RESET, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check("R3 reset held", S_RESET, 1'b0, 1'b0);
    p_done(); check("R3 reset done", S_IDLE, 1'b0, 1'b0);

    // R7: reset cancels pending power down
    goto(S_IDLE);
    strobe(C_PWD); strobe(C_RST); p_done();
    cs_up(); check("R7 pending cancelled", S_IDLE, 1'b0, 1'b0);

    // R6: latest deferred command wins
    goto(S_IDLE);
    strobe(C_PWD); strobe(C_XOFF);
    cs_up(); check("R6 latest deferred wins", S_XOFF, 1'b0, 1'b0);

    // R12: consecutive commands in one frame
    goto(S_IDLE);
    strobe(C_RX);   check("R12 first", S_RX, 1'b0, 1'b0);
    strobe(C_TX);   check("R12 second", S_TX, 1'b0, 1'b0);
    strobe(C_IDLE); check("R12 third", S_IDLE, 1'b0, 1'b0);
    strobe(C_FTX);  check("R12 fourth flush", S_IDLE, 1'b1, 1'b0);

    // R11: events
    goto(S_RX); p_unf(); check("R11 underflow ignored in RX", S_RX, 1'b0, 1'b0);
    p_ovf();            check("R11 overflow in RX", S_ROVF, 1'b0, 1'b0);
    goto(S_TX); p_ovf(); check("R11 overflow ignored in TX", S_TX, 1'b0, 1'b0);
    p_unf();            check("R11 underflow in TX", S_TUNF, 1'b0, 1'b0);
    goto(S_IDLE); p_unf(); p_ovf(); check("R11 events ignored in IDLE", S_IDLE, 1'b0, 1'b0);
    goto(S_TX);
    @(negedge clk); stb = 1'b1; addr = C_RX; tunf = 1'b1;
    @(negedge clk); stb = 1'b0; tunf = 1'b0;
    check("R11 command beats event", S_RX, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule